// File: doc/BRIEF.md
# Zone-Based Access Permission Checker

This block decides, one cycle after a translation hit, whether a memory access may proceed. It receives the matched entry's attribute byte, the entry's execute and write permission bits, and a valid flag. It also receives a 32-bit global zone register, the current privilege level and the kind of access: instruction fetch, data read or data write. It returns a grant flag, the read and write rights that apply, and a fault code. The fault code separates a missing entry, a protection violation and an execute denial.

The upper nibble of the attribute byte picks one of sixteen 2-bit zone fields in the zone register. The field value can deny, defer to the entry's own bits, or grant full access, and some values act differently for user and supervisor code. This is how software changes the protection of whole groups of pages at once without rewriting entries.

The block is a single registered stage. The zone field is extracted by a generate-built selector, mapped by a policy stage onto one of three modes (deny, entry, full), and resolved against the access kind. Registered outputs change only when a request is presented.

Top module: `zone_perm_check`

## Requirements
- R1: When `chk_req` is high at a rising edge, `chk_done` is high after that edge and the verdict outputs reflect that request. When `chk_req` is low, `chk_done` falls and `acc_grant`, `grant_rd`, `grant_wr` and `fault_code` keep their previous values.
- R2: The zone number is `ent_attr[7:4]`. Its 2-bit code is `zone_reg[31-2z : 30-2z]`, so zone 0 uses bits 31:30 and zone 15 uses bits 1:0.
- R3: If `ent_valid` is low, the verdict is no grant, no rights and fault code 1 (no entry), whatever the zone, privilege or access kind.
- R4: With zone code 0 in user mode (`user_mode`=1), every access kind is refused with zero rights and fault code 2 (protection violation).
- R5: With zone code 0 in supervisor mode, and with zone code 1 at either privilege level, the entry's own permission bits decide.
- R6: With zone code 2, user mode uses the entry's own bits and supervisor mode gets full access.
- R7: With zone code 3, every access kind is granted with read and write rights and fault code 0, even a fetch from an entry without execute permission.
- R8: When entry bits decide a fetch (`acc_kind`=0): if `ent_exec` is low, there is no grant, there are no rights, and the fault code is 3 (execute denied). Otherwise the fetch is granted with read right and write right equal to `ent_write`.
- R9: When entry bits decide a data access (`acc_kind` 1 = read, 2 = write, 3 treated as read), read right is 1 and write right equals `ent_write`. A read is always granted. A write is granted only when `ent_write` is 1, and otherwise reports fault code 2.
- R10: `acc_grant` is 1 exactly when `fault_code` is 0, and a refused access never reports write right.
- R11: After reset (`rst` high, synchronous), `chk_done`, `acc_grant`, `grant_rd`, `grant_wr` and `fault_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_req | input | 1 | A check is requested this cycle |
| ent_valid | input | 1 | Matched entry is valid |
| ent_attr | input | 8 | Entry attribute byte; bits 7:4 are the zone number |
| ent_exec | input | 1 | Entry allows execution |
| ent_write | input | 1 | Entry allows writes |
| zone_reg | input | 32 | Global zone register, sixteen 2-bit fields |
| user_mode | input | 1 | 1 = user privilege, 0 = supervisor |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| chk_done | output | 1 | Verdict registered from the previous cycle's request |
| acc_grant | output | 1 | Access allowed |
| grant_rd | output | 1 | Read right granted |
| grant_wr | output | 1 | Write right granted |
| fault_code | output | 2 | 0 none, 1 no entry, 2 protection, 3 execute denied |

## Verification
The checker watches on every cycle for the request-to-done timing and the holding of outputs when no request is made. It also checks that the grant agrees with the fault code, that a refused access never reports write right, that an invalid entry always gives the no-entry code, and that execute denial appears only for fetches. The extraction of the zone field position and the per-privilege meaning of each zone code can only be shown by the bench. Its directed cases cover every zone code at both privilege levels, zones at both ends of the register, and mixed random traffic compared each cycle with a behavioural model.

// File: rtl/zpc_pkg.sv
package zpc_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ZM_DENY  = 2'd0,
        ZM_ENTRY = 2'd1,
        ZM_FULL  = 2'd2
    } zmode_e;

    localparam logic [1:0] FLT_NONE  = 2'd0;
    localparam logic [1:0] FLT_NOENT = 2'd1;
    localparam logic [1:0] FLT_PROT  = 2'd2;
    localparam logic [1:0] FLT_EXEC  = 2'd3;

    typedef struct packed {
        logic       grant;
        logic       rd;
        logic       wr;
        logic [1:0] fault;
    } verdict_t;

endpackage

// File: rtl/zpc_zone_sel.sv
module zpc_zone_sel #(
    parameter int ZONES = 16,
    parameter int FW    = 2,
    localparam int ZW   = $clog2(ZONES),
    localparam int RW   = ZONES * FW
) (
    input  logic [RW-1:0] zone_reg,
    input  logic [ZW-1:0] zsel,
    output logic [FW-1:0] zcode
);
    logic [FW-1:0] fields [ZONES];

    // zone 0 sits at the most significant end of the register
    for (genvar z = 0; z < ZONES; z++) begin : g_field
        assign fields[z] = zone_reg[RW-1-z*FW -: FW];
    end

    assign zcode = fields[zsel];
endmodule

// File: rtl/zpc_policy.sv
module zpc_policy
    import zpc_pkg::*;
(
    input  logic [1:0] zcode,
    input  logic       user,
    output zmode_e     mode
);
    always_comb begin
        unique case (zcode)
            2'd0:    mode = user ? ZM_DENY  : ZM_ENTRY;
            2'd1:    mode = ZM_ENTRY;
            2'd2:    mode = user ? ZM_ENTRY : ZM_FULL;
            default: mode = ZM_FULL;
        endcase
    end
endmodule

// File: rtl/zpc_decide.sv
module zpc_decide
    import zpc_pkg::*;
(
    input  logic     valid,
    input  zmode_e   mode,
    input  acc_e     acc,
    input  logic     ex_ok,
    input  logic     wr_ok,
    output verdict_t v
);
    always_comb begin
        v = '0;
        if (!valid) begin
            v.fault = FLT_NOENT;
        end else begin
            unique case (mode)
                ZM_FULL: begin
                    v.grant = 1'b1;
                    v.rd    = 1'b1;
                    v.wr    = 1'b1;
                end
                ZM_DENY: begin
                    v.fault = FLT_PROT;
                end
                default: begin
                    if (acc == ACC_FETCH) begin
                        if (ex_ok) begin
                            v.grant = 1'b1;
                            v.rd    = 1'b1;
                            v.wr    = wr_ok;
                        end else begin
                            v.fault = FLT_EXEC;
                        end
                    end else begin
                        v.rd = 1'b1;
                        v.wr = wr_ok;
                        if (acc == ACC_STORE && !wr_ok) begin
                            v.fault = FLT_PROT;
                        end else begin
                            v.grant = 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/zone_perm_check.sv
module zone_perm_check
    import zpc_pkg::*;
#(
    parameter int ZONES    = 16,
    parameter int FW       = 2,
    parameter int ATTR_W   = 8,
    parameter int ZSEL_LSB = 4,
    localparam int ZW      = $clog2(ZONES),
    localparam int RW      = ZONES * FW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_req,
    input  logic              ent_valid,
    input  logic [ATTR_W-1:0] ent_attr,
    input  logic              ent_exec,
    input  logic              ent_write,
    input  logic [RW-1:0]     zone_reg,
    input  logic              user_mode,
    input  logic [1:0]        acc_kind,
    output logic              chk_done,
    output logic              acc_grant,
    output logic              grant_rd,
    output logic              grant_wr,
    output logic [1:0]        fault_code
);
    logic [FW-1:0] zcode;
    zmode_e        mode;
    verdict_t      nxt;
    verdict_t      held;

    zpc_zone_sel #(.ZONES(ZONES), .FW(FW)) i_sel (
        .zone_reg (zone_reg),
        .zsel     (ent_attr[ZSEL_LSB +: ZW]),
        .zcode    (zcode)
    );

    zpc_policy i_pol (
        .zcode (zcode[1:0]),
        .user  (user_mode),
        .mode  (mode)
    );

    zpc_decide i_dec (
        .valid (ent_valid),
        .mode  (mode),
        .acc   (acc_e'(acc_kind)),
        .ex_ok (ent_exec),
        .wr_ok (ent_write),
        .v     (nxt)
    );

    // register process
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_done <= 1'b0;
            held     <= '0;
        end else begin
            chk_done <= chk_req;
            if (chk_req) held <= nxt;
        end
    end

    // output process
    always_comb begin
        acc_grant  = held.grant;
        grant_rd   = held.rd;
        grant_wr   = held.wr;
        fault_code = held.fault;
    end
endmodule

// File: rtl/zpc_sva.sv
module zpc_sva (
    input logic       clk,
    input logic       rst,
    input logic       chk_req,
    input logic       ent_valid,
    input logic [1:0] acc_kind,
    input logic       chk_done,
    input logic       acc_grant,
    input logic       grant_rd,
    input logic       grant_wr,
    input logic [1:0] fault_code
);
    a_r1_done_follows: assert property (@(posedge clk) disable iff (rst)
        chk_req |=> chk_done);
    a_r1_idle_drops: assert property (@(posedge clk) disable iff (rst)
        !chk_req |=> !chk_done);
    a_r1_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !chk_req |=> ($stable(acc_grant) && $stable(fault_code) && $stable(grant_wr)));
    a_r10_grant_iff_clear: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> (acc_grant == (fault_code == 2'd0)));
    a_r10_no_wr_on_fault: assert property (@(posedge clk) disable iff (rst)
        (chk_done && fault_code != 2'd0) |-> !grant_wr);
    a_r3_invalid_entry: assert property (@(posedge clk) disable iff (rst)
        (chk_req && !ent_valid) |=> (fault_code == 2'd1 && !grant_rd));
    a_r8_exec_fetch_only: assert property (@(posedge clk) disable iff (rst)
        (chk_req && acc_kind != 2'd0) |=> (fault_code != 2'd3));
endmodule

bind zone_perm_check zpc_sva i_zpc_sva (
    .clk        (clk),
    .rst        (rst),
    .chk_req    (chk_req),
    .ent_valid  (ent_valid),
    .acc_kind   (acc_kind),
    .chk_done   (chk_done),
    .acc_grant  (acc_grant),
    .grant_rd   (grant_rd),
    .grant_wr   (grant_wr),
    .fault_code (fault_code)
);

// File: tb/test_zone_perm_check.sv
module test_zone_perm_check;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chk_req = 1'b0;
    logic        ent_valid = 1'b0;
    logic [7:0]  ent_attr = '0;
    logic        ent_exec = 1'b0;
    logic        ent_write = 1'b0;
    logic [31:0] zone_reg = '0;
    logic        user_mode = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic        chk_done, acc_grant, grant_rd, grant_wr;
    logic [1:0]  fault_code;

    int vectors = 0;
    int errors  = 0;
    bit ended   = 0;

    // expected registered state (behavioural model)
    int e_done = 0, e_grant = 0, e_rd = 0, e_wr = 0, e_fault = 0;

    always #5 clk = ~clk;

    zone_perm_check i_zone_perm_check (
        .clk(clk), .rst(rst), .chk_req(chk_req), .ent_valid(ent_valid),
        .ent_attr(ent_attr), .ent_exec(ent_exec), .ent_write(ent_write),
        .zone_reg(zone_reg), .user_mode(user_mode), .acc_kind(acc_kind),
        .chk_done(chk_done), .acc_grant(acc_grant), .grant_rd(grant_rd),
        .grant_wr(grant_wr), .fault_code(fault_code)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    task automatic compare(input string tag);
        int got;
        got = (int'(chk_done) << 5) | (int'(acc_grant) << 4) | (int'(grant_rd) << 3)
            | (int'(grant_wr) << 2) | int'(fault_code);
        vectors++;
        if (got != ((e_done << 5) | (e_grant << 4) | (e_rd << 3) | (e_wr << 2) | e_fault)) begin
            errors++;
            $display("FAIL %s: done/grant/rd/wr/fault actual %0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d",
                tag, chk_done, acc_grant, grant_rd, grant_wr, fault_code,
                e_done, e_grant, e_rd, e_wr, e_fault);
        end
    endtask

    // model: computes the verdict from the requirement text
    task automatic model(input bit req);
        int zone, code, full, deny;
        e_done = req;
        if (!req) return;
        zone = int'(ent_attr) / 16;
        code = int'((zone_reg >> (30 - 2 * zone)) & 32'd3);
        full = (code == 3) || (code == 2 && !user_mode);
        deny = (code == 0 && user_mode);
        e_grant = 0; e_rd = 0; e_wr = 0; e_fault = 0;
        if (!ent_valid) e_fault = 1;
        else if (full) begin e_grant = 1; e_rd = 1; e_wr = 1; end
        else if (deny) e_fault = 2;
        else if (acc_kind == 2'd0) begin
            if (ent_exec) begin e_grant = 1; e_rd = 1; e_wr = ent_write; end
            else e_fault = 3;
        end else begin
            e_rd = 1; e_wr = ent_write;
            if (acc_kind == 2'd2 && !ent_write) e_fault = 2;
            else e_grant = 1;
        end
    endtask

    // drive at falling edge, check at the next falling edge
    task automatic apply(input bit req, input bit v, input int zone, input int code,
                         input bit usr, input int acc, input bit ex, input bit wr,
                         input string tag);
        zone_reg  = 32'h5555_5555 ^ 32'hFFFF_FFFF; // background code 2 everywhere
        zone_reg[31 - 2 * zone -: 2] = code[1:0];
        ent_attr  = {zone[3:0], 4'hA};
        chk_req   = req; ent_valid = v; user_mode = usr;
        acc_kind  = acc[1:0]; ent_exec = ex; ent_write = wr;
        model(req);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R11 reset");
        rst = 1'b0;
        @(negedge clk);
        compare("R11 after reset");

        // R4 zone 0 user denial for all kinds
        for (int a = 0; a < 4; a++) apply(1, 1, 0, 0, 1, a, 1, 1, "R4 zone0 user");
        // R5 zone 0 supervisor and zone 1 use entry bits
        apply(1, 1, 0, 0, 0, 2, 1, 0, "R5 zone0 sup write no perm");
        apply(1, 1, 7, 1, 1, 0, 0, 1, "R5 zone1 user fetch");
        apply(1, 1, 7, 1, 0, 1, 0, 0, "R5 zone1 sup read");
        // R6 zone 2 both levels
        apply(1, 1, 3, 2, 1, 2, 1, 0, "R6 zone2 user write denied");
        apply(1, 1, 3, 2, 0, 2, 0, 0, "R6 zone2 sup full");
        // R7 zone 3
        apply(1, 1, 15, 3, 1, 0, 0, 0, "R7 zone3 fetch no exec");
        apply(1, 1, 15, 3, 0, 2, 0, 0, "R7 zone3 write");
        // R8 fetch via entry bits
        apply(1, 1, 9, 1, 0, 0, 0, 1, "R8 exec denied");
        apply(1, 1, 9, 1, 0, 0, 1, 0, "R8 exec granted");
        // R9 data via entry bits
        apply(1, 1, 9, 1, 1, 1, 0, 0, "R9 read");
        apply(1, 1, 9, 1, 1, 3, 0, 0, "R9 kind3 as read");
        apply(1, 1, 9, 1, 1, 2, 1, 1, "R9 write allowed");
        apply(1, 1, 9, 1, 1, 2, 0, 0, "R9 write denied");
        // R3 invalid entry under full zone
        apply(1, 0, 15, 3, 0, 1, 1, 1, "R3 invalid");
        // R2 field position: zone 15 code 0 user, zone 0 left at background 2
        apply(1, 1, 15, 0, 1, 1, 1, 1, "R2 zone15 low bits");
        apply(1, 1, 0, 3, 1, 0, 0, 0, "R2 zone0 high bits");
        // R1 hold when idle
        apply(0, 0, 0, 0, 1, 2, 0, 0, "R1 idle hold");
        apply(0, 1, 5, 3, 0, 0, 1, 1, "R1 idle hold again");
        apply(1, 1, 5, 1, 1, 2, 0, 0, "R1 request after idle");

        // R10 and mixed random traffic
        for (int i = 0; i < 400; i++) begin
            zone_reg  = $urandom;
            ent_attr  = 8'($urandom);
            chk_req   = ($urandom % 4) != 0;
            ent_valid = ($urandom % 8) != 0;
            user_mode = 1'($urandom);
            acc_kind  = 2'($urandom);
            ent_exec  = 1'($urandom);
            ent_write = 1'($urandom);
            model(chk_req);
            @(negedge clk);
            compare("R10 random");
        end

        // R11 reset again mid-run
        rst = 1'b1; chk_req = 1'b1;
        e_done = 0; e_grant = 0; e_rd = 0; e_wr = 0; e_fault = 0;
        @(negedge clk);
        compare("R11 reset mid-run");
        rst = 1'b0; chk_req = 1'b0;
        finish_run();
    end
endmodule